// File: doc/BRIEF.md
# Serial Four-Channel Mode Register Port

This block receives configuration for a four-channel device over a three-wire serial link, with a fourth wire for the load strobe. While the active-low select is low, each rising edge of the serial clock shifts one data bit into a 12-bit shift register. The first bit sent ends up in bit 0. When select rises, the shifted word is copied into an input register. Bits 0 to 5 of that word are a six-bit mode value. Bits 6 and 7 carry nothing. Bits 8 to 11 form a channel mask.

The active-low load strobe moves the mode value into the channel registers. While the strobe is low, every channel whose mask bit is set takes the mode value. A single word can therefore give the same mode to any group of channels at the same time. If the strobe is held low permanently, the channels follow each newly captured word.

All four serial inputs are asynchronous. They pass through a synchroniser into the `clk` domain, and all state is kept in that domain. Reset stands in for power-up: it clears every channel register and sets all four mask bits of the input register.

Top module: `scm_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further stimulus, all four channel mode outputs are 0.
- R2: The shift register holds the last 12 bits shifted in. The first of those bits lands in bit 0. The word in the shift register is copied to the input register on a rising edge of `sel_n`, and at no other time.
- R3: Bit k of the captured word (k = 0..5) appears on bit k of every channel output that is updated from that word.
- R4: Word bit 8+i (i = 0..3) enables the update of `chan<i>_mode`. A channel whose bit is 0 keeps its previous value through a load.
- R5: Word bits 6 and 7 have no effect on any channel output.
- R6: While `ld_n` is high, no channel output changes. While `ld_n` is low, the enabled channels take the input register's mode field.
- R7: With `ld_n` held low, enabled channels do not change while a word is being shifted in. They take the new mode value after the rising edge of `sel_n`.
- R8: Rising edges of `sclk` while `sel_n` is high do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset (power-up state) |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdin | input | 1 | Serial data, least significant bit first |
| sel_n | input | 1 | Active-low select; rising edge captures the word |
| ld_n | input | 1 | Active-low load strobe, level sensitive |
| chan0_mode | output | 6 | Mode register of channel 0 (mask bit 8) |
| chan1_mode | output | 6 | Mode register of channel 1 (mask bit 9) |
| chan2_mode | output | 6 | Mode register of channel 2 (mask bit 10) |
| chan3_mode | output | 6 | Mode register of channel 3 (mask bit 11) |

## Verification
Two events can land in the same `clk` cycle: capture of a word into the input register, and a transfer into the channel registers. This happens when `ld_n` is held low while `sel_n` rises. The bench provokes it by holding the strobe low across a full word. It then checks two things: that no channel moves while bits are still shifting, and that each enabled channel shows the new mode a few cycles after the select edge. A sweep over all sixteen masks checks that disabled channels keep their values through a load.

// File: rtl/scm_pkg.sv
package scm_pkg;
    localparam int MODE_BITS  = 6;
    localparam int PAD_BITS   = 2;
    localparam int CHANNELS   = 4;
    localparam int SYNC_DEPTH = 2;
    localparam int WORD_BITS  = MODE_BITS + PAD_BITS + CHANNELS;
endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pipe <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/scm_front.sv
module scm_front #(
    parameter int MODE_W = 6,
    parameter int PAD_W  = 2,
    parameter int NUM_CH = 4,
    localparam int WORD_W = MODE_W + PAD_W + NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdin_s,
    input  logic              sel_n_s,
    output logic [MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0] en_o
);
    localparam logic [WORD_W-1:0] IN_RST = {{NUM_CH{1'b1}}, {(MODE_W+PAD_W){1'b0}}};

    typedef struct packed {
        logic              sclk_prev;
        logic              sel_prev;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] inreg;
    } front_st_t;

    front_st_t st_d, st_q;
    logic shift_evt, cap_evt;

    always_comb begin
        st_d = st_q;
        shift_evt = !sel_n_s && sclk_s && !st_q.sclk_prev;
        cap_evt   = sel_n_s && !st_q.sel_prev;
        st_d.sclk_prev = sclk_s;
        st_d.sel_prev  = sel_n_s;
        if (shift_evt) st_d.shreg = {sdin_s, st_q.shreg[WORD_W-1:1]};
        if (cap_evt)   st_d.inreg = st_q.shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.sel_prev  <= 1'b1;
            st_q.shreg     <= '0;
            st_q.inreg     <= IN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.inreg[MODE_W-1:0];
    assign en_o   = st_q.inreg[WORD_W-1 -: NUM_CH];

    // R8
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> $stable(st_q.shreg));
    // R2
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_s && !st_q.sel_prev) |=> st_q.inreg == $past(st_q.shreg));
    // R2
    capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_n_s && !st_q.sel_prev) |=> $stable(st_q.inreg));
endmodule

// File: rtl/scm_bank.sv
module scm_bank #(
    parameter int MODE_W = 6,
    parameter int NUM_CH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_n_s,
    input  logic [MODE_W-1:0]              mode_i,
    input  logic [NUM_CH-1:0]              en_i,
    output logic [NUM_CH-1:0][MODE_W-1:0]  ch_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][MODE_W-1:0] ch;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!ld_n_s && en_i[i]) st_d.ch[i] = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ch <= '0;
        else        st_q <= st_d;
    end

    assign ch_o = st_q.ch;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R6
        no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld_n_s |=> $stable(st_q.ch[g]));
        // R4
        masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_n_s && !en_i[g]) |=> $stable(st_q.ch[g]));
        // R3
        load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_n_s && en_i[g]) |=> st_q.ch[g] == $past(mode_i));
    end
endmodule

// File: rtl/scm_top.sv
module scm_top #(
    parameter int MODE_W = scm_pkg::MODE_BITS,
    parameter int PAD_W  = scm_pkg::PAD_BITS,
    parameter int SYNC_N = scm_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              sel_n,
    input  logic              ld_n,
    output logic [MODE_W-1:0] chan0_mode,
    output logic [MODE_W-1:0] chan1_mode,
    output logic [MODE_W-1:0] chan2_mode,
    output logic [MODE_W-1:0] chan3_mode
);
    localparam int NUM_CH = 4;

    logic [3:0]                     pins_s;
    logic [MODE_W-1:0]              mode_w;
    logic [NUM_CH-1:0]              en_w;
    logic [NUM_CH-1:0][MODE_W-1:0]  ch_w;

    // order: ld_n, sel_n, sdin, sclk; strobes idle high
    scm_sync #(.WIDTH(4), .STAGES(SYNC_N), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ld_n, sel_n, sdin, sclk}),
        .sync_o  (pins_s)
    );

    scm_front #(.MODE_W(MODE_W), .PAD_W(PAD_W), .NUM_CH(NUM_CH)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[0]),
        .sdin_s  (pins_s[1]),
        .sel_n_s (pins_s[2]),
        .mode_o  (mode_w),
        .en_o    (en_w)
    );

    scm_bank #(.MODE_W(MODE_W), .NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_n_s (pins_s[3]),
        .mode_i (mode_w),
        .en_i   (en_w),
        .ch_o   (ch_w)
    );

    assign chan0_mode = ch_w[0];
    assign chan1_mode = ch_w[1];
    assign chan2_mode = ch_w[2];
    assign chan3_mode = ch_w[3];

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (ch_w == '0));
endmodule

// File: tb/scm_top_bench.sv
module scm_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdin = 1'b0, sel_n = 1'b1, ld_n = 1'b1;
    logic [5:0] chan0_mode, chan1_mode, chan2_mode, chan3_mode;

    int checks = 0;
    int errors = 0;

    logic [11:0] sh_m  = '0;
    logic [11:0] in_m  = 12'hF00;
    logic [5:0]  exp_m [4] = '{default: 6'd0};

    always #(CLK_PERIOD/2) clk = ~clk;

    scm_top u_scm_top (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sel_n(sel_n), .ld_n(ld_n),
        .chan0_mode(chan0_mode), .chan1_mode(chan1_mode),
        .chan2_mode(chan2_mode), .chan3_mode(chan3_mode)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [5:0] chan_val(input int i);
        case (i)
            0: chan_val = chan0_mode;
            1: chan_val = chan1_mode;
            2: chan_val = chan2_mode;
            default: chan_val = chan3_mode;
        endcase
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (chan_val(i) !== exp_m[i]) begin
                errors++;
                $display("FAIL %s chan%0d actual=%0h expected=%0h", tag, i, chan_val(i), exp_m[i]);
            end
        end
    endtask

    task automatic model_load();
        for (int i = 0; i < 4; i++) if (in_m[8+i]) exp_m[i] = in_m[5:0];
    endtask

    task automatic clock_bits(input logic [31:0] bits, input int n);
        for (int k = 0; k < n; k++) begin
            sdin = bits[k];
            wait_clk(HALF_SCK);
            sclk = 1'b1;
            wait_clk(HALF_SCK);
            sclk = 1'b0;
            if (!sel_n) sh_m = {bits[k], sh_m[11:1]};
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        sel_n = 1'b0;
        wait_clk(4);
        clock_bits(bits, n);
        wait_clk(HALF_SCK);
        sel_n = 1'b1;
        in_m = sh_m;
        wait_clk(8);
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        wait_clk(4);
        ld_n = 1'b1;
        model_load();
        wait_clk(6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(3);
        check_all("R1 in reset");
        rst_n = 1'b1;
        wait_clk(6);
        check_all("R1 after reset");

        // R3: walking one on each mode bit, all channels enabled
        for (int k = 0; k < 6; k++) begin
            send_bits(32'hF00 | (32'd1 << k), 12);
            pulse_load();
            check_all("R3 bit map");
        end

        // R4, R5: sweep every mask, pad bits vary
        for (int m = 0; m < 16; m++) begin
            logic [5:0] md;
            logic [1:0] pd;
            md = 6'((m * 13 + 7) % 64);
            pd = 2'(m);
            send_bits({20'd0, 4'(m), pd, md}, 12);
            check_all("R6 before load");
            pulse_load();
            check_all("R4 R5 mask sweep");
        end

        // R2: longer stream keeps only the last 12 bits
        send_bits(32'h0000_A5F3 | 32'h000F_0000, 20);
        pulse_load();
        check_all("R2 overlength");

        // R8: sclk edges with select high, then empty capture
        send_bits(32'h0000_F15, 12);
        sdin = 1'b1;
        for (int t = 0; t < 5; t++) begin
            sclk = 1'b1; wait_clk(HALF_SCK);
            sclk = 1'b0; wait_clk(HALF_SCK);
        end
        send_bits(32'd0, 0);
        pulse_load();
        check_all("R8 ignore sclk");

        // R7: strobe held low across a word
        ld_n = 1'b0;
        model_load();
        wait_clk(6);
        check_all("R7 hold low start");
        sel_n = 1'b0;
        wait_clk(4);
        clock_bits(32'h0000_A2C, 8);
        check_all("R7 mid shift");
        clock_bits(32'h0000_A2C >> 8, 4);
        wait_clk(HALF_SCK);
        sel_n = 1'b1;
        in_m = sh_m;
        model_load();
        wait_clk(8);
        check_all("R7 after select");
        ld_n = 1'b1;
        wait_clk(4);

        // R1: reset mid-run clears channels
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) exp_m[i] = '0;
        sh_m = '0;
        in_m = 12'hF00;
        wait_clk(3);
        check_all("R1 re-reset");
        rst_n = 1'b1;
        wait_clk(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule